// File: doc/BRIEF.md
# Next-Instruction Field Substitution Unit

This pipeline-stage block handles the three "alter" prefix instructions. When a prefix executes, the block adds its S and D operands and keeps the low 9 bits as a target address. That target is held as a pending substitution. The next instruction to execute then sees the target in place of one of its fields: the source field, the destination field, or the result field. The word held in instruction memory is never touched, because the block only rewrites the copy that is moving through the pipeline.

The prefix also writes a value back to its own D register: D plus the sign-extended 9-bit amount packed into S[17:9]. A program can use this to step an index through a table, with the table base and the step both carried in S.

Operand fetch and decode sit upstream of the block. They supply the executing instruction's word, its prefix type, and its resolved D and S values. The block returns the effective fields for the execute stage and a D write-back request for the register file. A flush from the pipeline drops any pending substitution.

Top module: `alt_subst_unit`

## Requirements
- R1: A prefix's target address is (S + D) mod 512, where S and D are the operand values the prefix presents.
- R2: After an alter-source prefix (pfx_kind = 1), the next executed instruction's source field (bits [8:0]) is replaced by the target. Its immediate-select bit (bit 18) and its destination field pass through unchanged.
- R3: After an alter-destination prefix (pfx_kind = 2), the next executed instruction's destination field (bits [17:9]) is replaced by the target. Its result address follows the new destination.
- R4: After an alter-result prefix (pfx_kind = 3), only the next executed instruction's result address is replaced by the target, and its destination field is unchanged. With nothing pending, the result address equals the destination field.
- R5: A prefix that executes without a flush asserts d_wr_en with d_wr_data = D + sign-extended S[17:9], computed mod 2^32, and d_wr_addr equal to the prefix's own result address. For a non-prefix instruction (pfx_kind = 0), or on a cycle with no executing instruction, d_wr_en is low.
- R6: When s_present is low, S is treated as zero. The target is then D[8:0] and the write-back value is D.
- R7: A pending substitution applies to exactly one executed instruction and is then cleared. Cycles with exec_valid low leave it pending. A prefix that consumes a pending substitution installs its own substitution in its place.
- R8: In a cycle with flush high, the instruction passes with no substitution and no write-back, nothing is captured, and any pending substitution is cleared.
- R9: After reset, nothing is pending and instruction fields pass through unmodified.
- R10: eff_insn equals exec_insn except for the substituted source or destination field. The same stored word presented again later, with nothing pending, comes out unmodified.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| flush | input | 1 | Pipeline flush; drops the pending substitution |
| exec_valid | input | 1 | An instruction executes this cycle |
| pfx_kind | input | 2 | 0 none, 1 alter-source, 2 alter-destination, 3 alter-result |
| exec_insn | input | 32 | Instruction word as fetched |
| d_val | input | 32 | D register value |
| s_val | input | 32 | S value, from a register or an immediate |
| s_present | input | 1 | Low when the S operand was omitted |
| eff_insn | output | 32 | Instruction word with the substituted field in place |
| eff_src | output | 9 | Effective source field |
| eff_dst | output | 9 | Effective destination field |
| eff_res | output | 9 | Effective result address |
| eff_imm | output | 1 | Immediate-select bit, passed through |
| d_wr_en | output | 1 | Write-back request for the prefix's D |
| d_wr_addr | output | 9 | Register written by the write-back |
| d_wr_data | output | 32 | Post-incremented D |

## Verification
The bench builds the block with its defaults: 32-bit data and words, 9-bit fields, the destination field at bit 9, and the immediate-select bit at 18. With 9-bit fields, the wrap of the target sum and the sign bit of the increment at S[17] are easy to reach with ordinary operands. Directed cases cover that wrap, negative increments, an omitted S, chained prefixes, idle gaps and flushes. A long random stream then mixes all four prefix kinds with bubbles and flushes.

// File: rtl/alt_pkg.sv
package alt_pkg;
  typedef enum logic [1:0] {
    ALT_NONE = 2'd0,
    ALT_SRC  = 2'd1,
    ALT_DST  = 2'd2,
    ALT_RES  = 2'd3
  } alt_kind_e;
endpackage

// File: rtl/alt_addr_calc.sv
module alt_addr_calc #(
  parameter int DATA_W  = 32,
  parameter int FIELD_W = 9,
  parameter int INC_LSB = 9
) (
  input  logic [DATA_W-1:0]  d_val,
  input  logic [DATA_W-1:0]  s_val,
  input  logic               s_present,
  output logic [FIELD_W-1:0] target,
  output logic [DATA_W-1:0]  d_next
);
  localparam int INC_MSB = INC_LSB + FIELD_W - 1;
  localparam int EXT_W   = DATA_W - FIELD_W;

  function automatic logic [FIELD_W-1:0] f_target(input logic [DATA_W-1:0] s,
                                                  input logic [DATA_W-1:0] d);
    logic [DATA_W-1:0] sum;
    sum = s + d;
    return sum[FIELD_W-1:0];
  endfunction

  function automatic logic [DATA_W-1:0] f_step(input logic [DATA_W-1:0] s,
                                               input logic [DATA_W-1:0] d);
    logic [DATA_W-1:0] inc;
    inc = {{EXT_W{s[INC_MSB]}}, s[INC_MSB:INC_LSB]};
    return d + inc;
  endfunction

  logic [DATA_W-1:0] s_eff;
  assign s_eff  = s_present ? s_val : '0;
  assign target = f_target(s_eff, d_val);
  assign d_next = f_step(s_eff, d_val);
endmodule

// File: rtl/alt_pend_reg.sv
module alt_pend_reg
  import alt_pkg::*;
#(
  parameter int FIELD_W = 9
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               flush,
  input  logic               consume,
  input  logic               capture,
  input  alt_kind_e          kind_in,
  input  logic [FIELD_W-1:0] addr_in,
  output logic               pend_valid,
  output alt_kind_e          pend_kind,
  output logic [FIELD_W-1:0] pend_addr
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_valid <= 1'b0;
      pend_kind  <= ALT_NONE;
      pend_addr  <= '0;
    end else if (flush) begin
      pend_valid <= 1'b0;
    end else if (capture) begin
      pend_valid <= 1'b1;
      pend_kind  <= kind_in;
      pend_addr  <= addr_in;
    end else if (consume) begin
      pend_valid <= 1'b0;
    end
  end

  // R7: used once, then gone
  a_r7_single_use: assert property (@(posedge clk) disable iff (!rst_n)
    (consume && !capture && !flush) |=> !pend_valid);
  // R7: idle cycles keep the pending substitution
  a_r7_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!consume && !flush) |=> ($stable(pend_valid) && $stable(pend_addr)));
  // R8: flush empties the slot
  a_r8_flush_clears: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !pend_valid);
  a_r1_capture_kind: assert property (@(posedge clk) disable iff (!rst_n)
    (capture && !flush) |=> (pend_valid && pend_kind != ALT_NONE));
endmodule

// File: rtl/alt_field_mux.sv
module alt_field_mux
  import alt_pkg::*;
#(
  parameter int INSN_W  = 32,
  parameter int FIELD_W = 9,
  parameter int SRC_LSB = 0,
  parameter int DST_LSB = 9,
  parameter int IMM_BIT = 18
) (
  input  logic [INSN_W-1:0]  insn,
  input  logic               apply,
  input  alt_kind_e          kind,
  input  logic [FIELD_W-1:0] addr,
  output logic [INSN_W-1:0]  eff_insn,
  output logic [FIELD_W-1:0] eff_src,
  output logic [FIELD_W-1:0] eff_dst,
  output logic [FIELD_W-1:0] eff_res,
  output logic               eff_imm
);
  logic sel_src, sel_dst, sel_res;
  assign sel_src = apply && (kind == ALT_SRC);
  assign sel_dst = apply && (kind == ALT_DST);
  assign sel_res = apply && (kind == ALT_RES);

  assign eff_src = sel_src ? addr : insn[SRC_LSB +: FIELD_W];
  assign eff_dst = sel_dst ? addr : insn[DST_LSB +: FIELD_W];
  // result address tracks the destination unless redirected on its own
  assign eff_res = sel_res ? addr : eff_dst;
  assign eff_imm = insn[IMM_BIT];

  always_comb begin
    eff_insn = insn;
    eff_insn[SRC_LSB +: FIELD_W] = eff_src;
    eff_insn[DST_LSB +: FIELD_W] = eff_dst;
  end
endmodule

// File: rtl/alt_subst_unit.sv
module alt_subst_unit
  import alt_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int INSN_W  = 32,
  parameter int FIELD_W = 9,
  parameter int SRC_LSB = 0,
  parameter int DST_LSB = 9,
  parameter int IMM_BIT = 18,
  parameter int INC_LSB = 9
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               flush,
  input  logic               exec_valid,
  input  logic [1:0]         pfx_kind,
  input  logic [INSN_W-1:0]  exec_insn,
  input  logic [DATA_W-1:0]  d_val,
  input  logic [DATA_W-1:0]  s_val,
  input  logic               s_present,
  output logic [INSN_W-1:0]  eff_insn,
  output logic [FIELD_W-1:0] eff_src,
  output logic [FIELD_W-1:0] eff_dst,
  output logic [FIELD_W-1:0] eff_res,
  output logic               eff_imm,
  output logic               d_wr_en,
  output logic [FIELD_W-1:0] d_wr_addr,
  output logic [DATA_W-1:0]  d_wr_data
);
  alt_kind_e          kind_in;
  logic               step_live;   // an instruction retires this cycle
  logic               pfx_live;    // that instruction is a prefix
  logic [FIELD_W-1:0] target;
  logic [DATA_W-1:0]  d_next;
  logic               pend_valid;
  alt_kind_e          pend_kind;
  logic [FIELD_W-1:0] pend_addr;
  logic               apply;

  assign kind_in   = alt_kind_e'(pfx_kind);
  assign step_live = exec_valid && !flush;
  assign pfx_live  = step_live && (kind_in != ALT_NONE);
  assign apply     = step_live && pend_valid;

  alt_addr_calc #(.DATA_W(DATA_W), .FIELD_W(FIELD_W), .INC_LSB(INC_LSB)) u_calc (
    .d_val(d_val), .s_val(s_val), .s_present(s_present),
    .target(target), .d_next(d_next)
  );

  alt_pend_reg #(.FIELD_W(FIELD_W)) u_pend (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .consume(step_live), .capture(pfx_live),
    .kind_in(kind_in), .addr_in(target),
    .pend_valid(pend_valid), .pend_kind(pend_kind), .pend_addr(pend_addr)
  );

  alt_field_mux #(.INSN_W(INSN_W), .FIELD_W(FIELD_W), .SRC_LSB(SRC_LSB),
                  .DST_LSB(DST_LSB), .IMM_BIT(IMM_BIT)) u_mux (
    .insn(exec_insn), .apply(apply), .kind(pend_kind), .addr(pend_addr),
    .eff_insn(eff_insn), .eff_src(eff_src), .eff_dst(eff_dst),
    .eff_res(eff_res), .eff_imm(eff_imm)
  );

  assign d_wr_en   = pfx_live;
  assign d_wr_addr = eff_res;
  assign d_wr_data = d_next;

  // R5: write-back only from a live prefix
  a_r5_wb_gate: assert property (@(posedge clk) disable iff (!rst_n)
    d_wr_en |-> (exec_valid && !flush && pfx_kind != 2'd0));
  // R1: captured target is the masked sum of the operands seen
  a_r1_target_sum: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_valid && !flush && pfx_kind != 2'd0) |=>
      (pend_addr == FIELD_W'($past(s_present ? s_val : '0) + $past(d_val))));
  // R4: a result redirect leaves the destination field alone
  a_r4_dst_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (apply && pend_kind == ALT_RES) |-> (eff_dst == exec_insn[DST_LSB +: FIELD_W]));
  // R9: nothing pending just after reset
  a_r9_reset_clear: assert property (@(posedge clk)
    !rst_n |=> !pend_valid);
  // R8: a flushed instruction is never altered
  a_r8_no_subst_on_flush: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> (eff_insn == exec_insn));
endmodule

// File: tb/tb_alt_subst_unit.sv
module tb_alt_subst_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        flush, exec_valid, s_present;
  logic [1:0]  pfx_kind;
  logic [31:0] exec_insn, d_val, s_val;
  logic [31:0] eff_insn, d_wr_data;
  logic [8:0]  eff_src, eff_dst, eff_res, d_wr_addr;
  logic        eff_imm, d_wr_en;

  int checks = 0, fails = 0;
  bit done = 0;

  // reference state
  bit       m_valid;
  int       m_kind;
  bit [8:0] m_addr;

  always #10 clk = ~clk;  // 50 MHz

  alt_subst_unit dut (
    .clk(clk), .rst_n(rst_n), .flush(flush), .exec_valid(exec_valid),
    .pfx_kind(pfx_kind), .exec_insn(exec_insn), .d_val(d_val), .s_val(s_val),
    .s_present(s_present), .eff_insn(eff_insn), .eff_src(eff_src),
    .eff_dst(eff_dst), .eff_res(eff_res), .eff_imm(eff_imm),
    .d_wr_en(d_wr_en), .d_wr_addr(d_wr_addr), .d_wr_data(d_wr_data)
  );

  task automatic chk(string req, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s (%s): actual %h expected %h", req, tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  // one pipeline cycle: drive at negedge, compare mid-low-phase, advance model at posedge
  task automatic step(string tag, bit v, int k, logic [31:0] d, logic [31:0] s,
                      bit sp, logic [31:0] insn, bit fl);
    bit apply, wen;
    logic [8:0] e_src, e_dst, e_res;
    logic [31:0] se, inc, e_insn, e_wd;
    int sum;
    @(negedge clk);
    exec_valid = v; pfx_kind = 2'(k); d_val = d; s_val = s;
    s_present = sp; exec_insn = insn; flush = fl;
    #5;
    apply = m_valid && v && !fl;
    e_src = (apply && m_kind == 1) ? m_addr : insn[8:0];
    e_dst = (apply && m_kind == 2) ? m_addr : insn[17:9];
    e_res = (apply && m_kind == 3) ? m_addr : e_dst;
    e_insn = insn;
    e_insn[8:0] = e_src;
    e_insn[17:9] = e_dst;
    se = sp ? s : 32'd0;
    inc = se[17] ? (32'hFFFF_FE00 | 32'(se[17:9])) : 32'(se[17:9]);
    e_wd = d + inc;
    wen = v && !fl && k != 0;
    chk("R10", tag, eff_insn, e_insn);
    chk("R2", tag, 32'(eff_src), 32'(e_src));
    chk("R2", tag, 32'(eff_imm), 32'(insn[18]));
    chk("R3", tag, 32'(eff_dst), 32'(e_dst));
    chk("R4", tag, 32'(eff_res), 32'(e_res));
    chk("R5", tag, 32'(d_wr_en), 32'(wen));
    if (wen) begin
      chk("R5", tag, d_wr_data, e_wd);
      chk("R4", tag, 32'(d_wr_addr), 32'(e_res));
    end
    @(posedge clk);
    if (fl) m_valid = 0;
    else if (v && k != 0) begin
      sum = int'(se[8:0]) + int'(d[8:0]);
      m_valid = 1; m_kind = k; m_addr = 9'(sum % 512);
    end else if (v) m_valid = 0;
  endtask

  initial begin
    #(20 * 200000);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    rst_n = 0; flush = 0; exec_valid = 0; pfx_kind = 0; s_present = 0;
    exec_insn = 0; d_val = 0; s_val = 0;
    m_valid = 0; m_kind = 0; m_addr = 0;
    repeat (3) @(posedge clk);
    #3 rst_n = 1;
    // R9: reset state, plain instruction unmodified
    step("R9 reset", 1, 0, 0, 0, 1, 32'h0004_A2B3, 0);
    // R1/R2: alter-source with a sum that wraps past 9 bits
    step("R1 wrap", 1, 1, 32'h0000_01F0, 32'h0000_0020, 1, 32'h0, 0);
    step("R2 src", 1, 0, 0, 0, 1, 32'h0005_5C3F, 0);
    // R3: alter-destination, result follows
    step("R3 pfx", 1, 2, 32'h0000_0010, 32'h0000_0105, 1, 32'h0, 0);
    step("R3 dst", 1, 0, 0, 0, 1, 32'hABC0_0111, 0);
    // R4 and R5: alter-result with negative step (-1)
    step("R5 neg", 1, 3, 32'h0000_0000, 32'h0003_FE07, 1, 32'h0, 0);
    step("R4 res", 1, 0, 0, 0, 1, 32'h0000_3E01, 0);
    // R6: S omitted
    step("R6 noS", 1, 1, 32'hFFFF_FF7B, 32'hFFFF_FFFF, 0, 32'h0, 0);
    // R7: bubbles keep pending, then single use, then gone
    step("R7 idle", 0, 0, 0, 0, 1, 32'h1234_5678, 0);
    step("R7 idle2", 0, 2, 5, 5, 1, 32'h1234_5678, 0);
    step("R7 use", 1, 0, 0, 0, 1, 32'h0000_0155, 0);
    step("R7 gone", 1, 0, 0, 0, 1, 32'h0000_0155, 0);
    // R7: chained prefixes; the second is altered and installs its own
    step("R7 chain1", 1, 2, 32'h0000_0001, 32'h0000_0002, 1, 32'h0, 0);
    step("R7 chain2", 1, 1, 32'h0000_0040, 32'h0000_0200, 1, 32'h0000_0600, 0);
    step("R7 chain3", 1, 0, 0, 0, 1, 32'h0007_FFFF, 0);
    // R8: flush drops pending and blocks capture/write-back
    step("R8 pfx", 1, 3, 32'h0000_0033, 32'h0000_0011, 1, 32'h0, 0);
    step("R8 flush", 1, 1, 32'h0000_0099, 32'h0000_0001, 1, 32'h0000_0ABC, 1);
    step("R8 after", 1, 0, 0, 0, 1, 32'h0000_0ABC, 0);
    // R10: same stored word later, unmodified
    step("R10 pfx", 1, 1, 32'h0000_0007, 0, 1, 32'h0, 0);
    step("R10 a", 1, 0, 0, 0, 1, 32'h00F0_F0F0, 0);
    step("R10 b", 1, 0, 0, 0, 1, 32'h00F0_F0F0, 0);
    // mixed random stream
    for (int i = 0; i < 3000; i++) begin
      step("R1 rand", ($urandom % 4) != 0, int'($urandom % 4), $urandom, $urandom,
           ($urandom % 8) != 0, $urandom, ($urandom % 16) == 0);
    end
    finish_run();
  end
endmodule